// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Command Register

This block holds a two-way set-associative translation buffer whose entries are placed, inspected and searched only by system software. Software reaches it through a small register window: two descriptor registers that carry one entry's tag half and data half, an index register that names a slot, a process register that holds the current address-space number and the translation enable, and a command register. Each write to the command register runs one numbered operation in a single clock cycle. The operations are: store the descriptors into the slot named by the index, fetch a slot into the descriptors, search for the descriptor tag, pick a replacement slot, and flush the small per-pipeline translation caches that sit outside this block.

A combinational lookup port translates a virtual address under the current address-space number. It returns a hit flag, the physical page and the attribute bits. The downstream translation caches are not part of the block; it only drives a one-cycle flush strobe to them. Pages are 8 KB and there are 128 sets, so the set comes from address bits 19:13.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset the descriptor, index and process registers read 0, every slot is invalid and the flush strobe is low.
- R2: The register window is selected by reg_sel: 0 tag descriptor, 1 data descriptor, 2 index, 3 command (reads 0), 4 process; the other registers read back exactly what was written.
- R3: Command code 1 (reg_wdata[3:0]) stores into slot index[7:0] (bit 0 way, bits 7:1 set) the tag descriptor's page number [31:13], valid [9], global [8] and address-space number [7:0], and the data descriptor's physical page [31:13] and attributes [6:0]; the flush strobe is high for exactly the one cycle after the command.
- R4: Command code 5 stores a slot exactly like code 1 but leaves the flush strobe low.
- R5: Command code 6 raises the flush strobe for the one cycle after the command and changes no register or slot.
- R6: Command code 2 loads both descriptors from slot index[7:0]; the bits that a slot does not hold read back as 0.
- R7: Command code 4 searches the set given by tag-descriptor bits 19:13 for a valid slot whose page number matches and whose address-space number matches or whose global bit is set; on a hit the index becomes {set, way}, and the lower way wins when both match.
- R8: A search with no match loads 0x80000000 into the index register.
- R9: Command code 3 loads the index with {set of the tag descriptor, bit 0 of an 8-bit shift register}; the shift register starts at 0xA5, and each code 3 moves it to {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R10: With process bit 31 set, the lookup port hits when a valid slot in set vaddr[19:13] has page number vaddr[31:13] and either the address-space number of process bits 7:0 or the global bit; it returns that slot's physical page and attributes, and 0 for both on a miss.
- R11: With process bit 31 clear, the lookup port always hits with physical page vaddr[31:13] and attributes 0x3F.
- R12: Command codes 0 and 7 to 15 change no register, no slot and do not raise the flush strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register window write strobe |
| reg_sel | input | 3 | Register window select |
| reg_wdata | input | 32 | Register window write data |
| reg_rdata | output | 32 | Register window read data of the selected register |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 19 | Physical page number of the hit |
| lk_attr | output | 7 | Attribute bits of the hit |
| utlb_inv | output | 1 | One-cycle flush strobe for the downstream translation caches |

## Verification
A slot written to the wrong place or with a corrupt tag shows up at once on the lookup port as a missed or wrong translation, and on the next search as the error code or a wrong way in the index. A wrong replacement-register state is visible on the first pick command after it, as bit 0 of the index. A misdecoded command shows the cycle after it, in the flush strobe or in a descriptor that changed when it should not have.

// File: rtl/tlb_cmd_pkg.sv
package tlb_cmd_pkg;
   localparam int REG_W          = 32;
   localparam int CMD_W          = 4;
   localparam int SEL_W          = 3;
   localparam int ASID_W         = 8;
   localparam int ATTR_W         = 7;
   localparam int PD0_VALID_BIT  = 9;
   localparam int PD0_GLOBAL_BIT = 8;
   localparam int PID_EN_BIT     = 31;
   localparam logic [REG_W-1:0]  PROBE_MISS  = 32'h8000_0000;
   localparam logic [ATTR_W-1:0] ATTR_BYPASS = 7'h3F;

   typedef enum logic [CMD_W-1:0] {
      CMD_WRITE       = 4'd1,
      CMD_READ        = 4'd2,
      CMD_PICK        = 4'd3,
      CMD_SEARCH      = 4'd4,
      CMD_WRITE_QUIET = 4'd5,
      CMD_FLUSH       = 4'd6
   } tlb_cmd_e;

   typedef enum logic [SEL_W-1:0] {
      SEL_TAGD  = 3'd0,
      SEL_DATAD = 3'd1,
      SEL_INDEX = 3'd2,
      SEL_CMD   = 3'd3,
      SEL_PROC  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
   parameter int          W    = 8,
   parameter logic [W-1:0] SEED = 8'hA5,
   parameter logic [W-1:0] TAPS = 8'hB8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("tlb_lfsr: seed must be nonzero");
      end
   endgenerate

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int SET_W  = 7,
   parameter int WAYS   = 2,
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8,
   parameter int ATTR_W = 7,
   parameter int NQ     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic                              wr_en,
   input  logic [SET_W+$clog2(WAYS)-1:0]     wr_idx,
   input  logic [VPN_W-1:0]                  wr_vpn,
   input  logic [ASID_W-1:0]                 wr_asid,
   input  logic                              wr_glob,
   input  logic                              wr_valid,
   input  logic [VPN_W-1:0]                  wr_ppn,
   input  logic [ATTR_W-1:0]                 wr_attr,
   input  logic [SET_W+$clog2(WAYS)-1:0]     rd_idx,
   output logic [VPN_W-1:0]                  rd_vpn,
   output logic [ASID_W-1:0]                 rd_asid,
   output logic                              rd_glob,
   output logic                              rd_valid,
   output logic [VPN_W-1:0]                  rd_ppn,
   output logic [ATTR_W-1:0]                 rd_attr,
   input  logic [NQ-1:0][SET_W-1:0]          q_set,
   output logic [NQ-1:0][WAYS-1:0][VPN_W-1:0]  q_vpn,
   output logic [NQ-1:0][WAYS-1:0][ASID_W-1:0] q_asid,
   output logic [NQ-1:0][WAYS-1:0]             q_glob,
   output logic [NQ-1:0][WAYS-1:0]             q_valid,
   output logic [NQ-1:0][WAYS-1:0][VPN_W-1:0]  q_ppn,
   output logic [NQ-1:0][WAYS-1:0][ATTR_W-1:0] q_attr
);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int IDX_W   = SET_W + WAY_W;
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TAG_W   = VPN_W + ASID_W + 1;
   localparam int DAT_W   = VPN_W + ATTR_W;

   logic [TAG_W-1:0]   tag_mem [ENTRIES];
   logic [DAT_W-1:0]   dat_mem [ENTRIES];
   logic [ENTRIES-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx] <= {wr_vpn, wr_asid, wr_glob};
         dat_mem[wr_idx] <= {wr_ppn, wr_attr};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= wr_valid;
   end

   assign {rd_vpn, rd_asid, rd_glob} = tag_mem[rd_idx];
   assign {rd_ppn, rd_attr}          = dat_mem[rd_idx];
   assign rd_valid                   = valid_q[rd_idx];

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_port
         for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [IDX_W-1:0] slot;
            assign slot = {q_set[q], WAY_W'(w)};
            assign {q_vpn[q][w], q_asid[q][w], q_glob[q][w]} = tag_mem[slot];
            assign {q_ppn[q][w], q_attr[q][w]}               = dat_mem[slot];
            assign q_valid[q][w]                              = valid_q[slot];
         end
      end
   endgenerate
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
   parameter int WAYS   = 2,
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic [WAYS-1:0][VPN_W-1:0]  way_vpn,
   input  logic [WAYS-1:0][ASID_W-1:0] way_asid,
   input  logic [WAYS-1:0]             way_glob,
   input  logic [WAYS-1:0]             way_valid,
   input  logic [VPN_W-1:0]            key_vpn,
   input  logic [ASID_W-1:0]           key_asid,
   output logic                        hit,
   output logic [$clog2(WAYS)-1:0]     hit_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] match;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign match[w] = way_valid[w] && (way_vpn[w] == key_vpn) &&
                           (way_glob[w] || (way_asid[w] == key_asid));
      end
   endgenerate

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |match;
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
   import tlb_cmd_pkg::*;
#(
   parameter int          PAGE_BITS = 13,
   parameter int          SET_W     = 7,
   parameter int          WAYS      = 2,
   parameter int          LFSR_W    = 8,
   parameter logic [7:0]  LFSR_SEED = 8'hA5,
   parameter logic [7:0]  LFSR_TAPS = 8'hB8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [2:0]                  reg_sel,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   input  logic [31:0]                 lk_vaddr,
   output logic                        lk_hit,
   output logic [31-PAGE_BITS:0]       lk_ppn,
   output logic [6:0]                  lk_attr,
   output logic                        utlb_inv
);
   localparam int VPN_W    = REG_W - PAGE_BITS;
   localparam int WAY_W    = $clog2(WAYS);
   localparam int IDX_BITS = SET_W + WAY_W;
   localparam int NQ       = 2;
   localparam int QS       = 0;
   localparam int QL       = 1;

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("tlb_cmd_engine: WAYS must be a power of two of at least 2");
      end
      if (PAGE_BITS <= PD0_VALID_BIT || PAGE_BITS <= ATTR_W) begin : g_bad_page
         $error("tlb_cmd_engine: page offset too small for descriptor flags");
      end
      if (SET_W > VPN_W || IDX_BITS >= REG_W - 1) begin : g_bad_sets
         $error("tlb_cmd_engine: set field does not fit");
      end
      if (WAY_W > LFSR_W || LFSR_W != 8) begin : g_bad_lfsr
         $error("tlb_cmd_engine: replacement register width mismatch");
      end
   endgenerate

   logic [REG_W-1:0] pd0_q, pd1_q, idx_q, pid_q;

   logic                  cmd_fire;
   logic [CMD_W-1:0]      cmd_code;
   logic                  do_store, do_strobe, do_pick;
   logic [VPN_W-1:0]      pd0_vpn, pd1_ppn, lk_vpn;
   logic [SET_W-1:0]      pd0_set, lk_set;
   logic [ASID_W-1:0]     pd0_asid, cur_asid;
   logic [IDX_BITS-1:0]   slot_idx;
   logic [LFSR_W-1:0]     lfsr_q;

   assign cmd_fire = reg_we && (reg_sel == SEL_CMD);
   assign cmd_code = reg_wdata[CMD_W-1:0];
   assign pd0_vpn  = pd0_q[REG_W-1:PAGE_BITS];
   assign pd1_ppn  = pd1_q[REG_W-1:PAGE_BITS];
   assign pd0_set  = pd0_vpn[SET_W-1:0];
   assign pd0_asid = pd0_q[ASID_W-1:0];
   assign lk_vpn   = lk_vaddr[REG_W-1:PAGE_BITS];
   assign lk_set   = lk_vpn[SET_W-1:0];
   assign cur_asid = pid_q[ASID_W-1:0];
   assign slot_idx = idx_q[IDX_BITS-1:0];

   always_comb begin
      do_store  = 1'b0;
      do_strobe = 1'b0;
      do_pick   = 1'b0;
      if (cmd_fire) begin
         case (cmd_code)
            CMD_WRITE:       begin do_store = 1'b1; do_strobe = 1'b1; end
            CMD_WRITE_QUIET: do_store  = 1'b1;
            CMD_FLUSH:       do_strobe = 1'b1;
            CMD_PICK:        do_pick   = 1'b1;
            default:         ;
         endcase
      end
   end

   // Replacement way source
   tlb_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (do_pick),
      .state (lfsr_q)
   );

   // Entry storage
   logic [VPN_W-1:0]  rd_vpn, rd_ppn;
   logic [ASID_W-1:0] rd_asid;
   logic              rd_glob, rd_valid;
   logic [ATTR_W-1:0] rd_attr;
   logic [NQ-1:0][SET_W-1:0]            q_set;
   logic [NQ-1:0][WAYS-1:0][VPN_W-1:0]  q_vpn, q_ppn;
   logic [NQ-1:0][WAYS-1:0][ASID_W-1:0] q_asid;
   logic [NQ-1:0][WAYS-1:0]             q_glob, q_valid;
   logic [NQ-1:0][WAYS-1:0][ATTR_W-1:0] q_attr;

   assign q_set[QS] = pd0_set;
   assign q_set[QL] = lk_set;

   tlb_store #(
      .SET_W(SET_W), .WAYS(WAYS), .VPN_W(VPN_W),
      .ASID_W(ASID_W), .ATTR_W(ATTR_W), .NQ(NQ)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (do_store),
      .wr_idx   (slot_idx),
      .wr_vpn   (pd0_vpn),
      .wr_asid  (pd0_asid),
      .wr_glob  (pd0_q[PD0_GLOBAL_BIT]),
      .wr_valid (pd0_q[PD0_VALID_BIT]),
      .wr_ppn   (pd1_ppn),
      .wr_attr  (pd1_q[ATTR_W-1:0]),
      .rd_idx   (slot_idx),
      .rd_vpn   (rd_vpn),
      .rd_asid  (rd_asid),
      .rd_glob  (rd_glob),
      .rd_valid (rd_valid),
      .rd_ppn   (rd_ppn),
      .rd_attr  (rd_attr),
      .q_set    (q_set),
      .q_vpn    (q_vpn),
      .q_asid   (q_asid),
      .q_glob   (q_glob),
      .q_valid  (q_valid),
      .q_ppn    (q_ppn),
      .q_attr   (q_attr)
   );

   // Tag comparators: one for the search command, one for the lookup port
   logic [NQ-1:0][VPN_W-1:0]  key_vpn;
   logic [NQ-1:0][ASID_W-1:0] key_asid;
   logic [NQ-1:0]             m_hit;
   logic [NQ-1:0][WAY_W-1:0]  m_way;

   assign key_vpn[QS]  = pd0_vpn;
   assign key_asid[QS] = pd0_asid;
   assign key_vpn[QL]  = lk_vpn;
   assign key_asid[QL] = cur_asid;

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_match
         tlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
            .way_vpn   (q_vpn[q]),
            .way_asid  (q_asid[q]),
            .way_glob  (q_glob[q]),
            .way_valid (q_valid[q]),
            .key_vpn   (key_vpn[q]),
            .key_asid  (key_asid[q]),
            .hit       (m_hit[q]),
            .hit_way   (m_way[q])
         );
      end
   endgenerate

   // Register window and command execution
   logic [REG_W-1:0] rd_pd0, rd_pd1;
   assign rd_pd0 = (REG_W'(rd_vpn) << PAGE_BITS) |
                   (REG_W'(rd_valid) << PD0_VALID_BIT) |
                   (REG_W'(rd_glob) << PD0_GLOBAL_BIT) |
                   REG_W'(rd_asid);
   assign rd_pd1 = (REG_W'(rd_ppn) << PAGE_BITS) | REG_W'(rd_attr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd0_q    <= '0;
         pd1_q    <= '0;
         idx_q    <= '0;
         pid_q    <= '0;
         utlb_inv <= 1'b0;
      end else begin
         utlb_inv <= do_strobe;
         if (reg_we) begin
            case (reg_sel)
               SEL_TAGD:  pd0_q <= reg_wdata;
               SEL_DATAD: pd1_q <= reg_wdata;
               SEL_INDEX: idx_q <= reg_wdata;
               SEL_PROC:  pid_q <= reg_wdata;
               SEL_CMD: begin
                  case (cmd_code)
                     CMD_READ: begin
                        pd0_q <= rd_pd0;
                        pd1_q <= rd_pd1;
                     end
                     CMD_PICK:   idx_q <= REG_W'({pd0_set, lfsr_q[WAY_W-1:0]});
                     CMD_SEARCH: idx_q <= m_hit[QS] ? REG_W'({pd0_set, m_way[QS]})
                                                    : PROBE_MISS;
                     default: ;
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_TAGD:  reg_rdata = pd0_q;
         SEL_DATAD: reg_rdata = pd1_q;
         SEL_INDEX: reg_rdata = idx_q;
         SEL_PROC:  reg_rdata = pid_q;
         default:   reg_rdata = '0;
      endcase
   end

   // Lookup port
   always_comb begin
      if (!pid_q[PID_EN_BIT]) begin
         lk_hit  = 1'b1;
         lk_ppn  = lk_vpn;
         lk_attr = ATTR_BYPASS;
      end else if (m_hit[QL]) begin
         lk_hit  = 1'b1;
         lk_ppn  = q_ppn[QL][m_way[QL]];
         lk_attr = q_attr[QL][m_way[QL]];
      end else begin
         lk_hit  = 1'b0;
         lk_ppn  = '0;
         lk_attr = '0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{lk_vaddr[PAGE_BITS-1:0], q_ppn[QS], q_attr[QS],
                          lfsr_q, pd0_q[PAGE_BITS-1:PD0_VALID_BIT+1],
                          pd1_q[PAGE_BITS-1:ATTR_W], pid_q[PID_EN_BIT-1:ASID_W]};
endmodule

// File: rtl/tlb_cmd_engine_chk.sv
module tlb_cmd_engine_chk #(
   parameter int IDX_BITS  = 8,
   parameter int SET_W     = 7,
   parameter int WAY_W     = 1,
   parameter int PAGE_BITS = 13
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [2:0]  reg_sel,
   input logic [31:0] reg_wdata,
   input logic        utlb_inv,
   input logic [31:0] pd0_q,
   input logic [31:0] pd1_q,
   input logic [31:0] idx_q,
   input logic [31:0] pid_q
);
   logic       fire;
   logic [3:0] code;
   assign fire = reg_we && (reg_sel == 3'd3);
   assign code = reg_wdata[3:0];

   // R3 R5
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      utlb_inv |-> $past(fire && (code == 4'd1 || code == 4'd6)));

   // R4
   quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && code == 4'd5) |=> !utlb_inv);

   // R7 R8
   search_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && code == 4'd4) |=>
         (idx_q == 32'h8000_0000) || (idx_q[31:IDX_BITS] == '0));

   // R9
   pick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && code == 4'd3) |=>
         (idx_q[IDX_BITS-1:WAY_W] == $past(pd0_q[PAGE_BITS+SET_W-1:PAGE_BITS])) &&
         (idx_q[31:IDX_BITS] == '0));

   // R12
   unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (code == 4'd0 || code > 4'd6)) |=>
         $stable(pd0_q) && $stable(pd1_q) && $stable(idx_q) && $stable(pid_q) && !utlb_inv);
endmodule

bind tlb_cmd_engine tlb_cmd_engine_chk #(
   .IDX_BITS(IDX_BITS), .SET_W(SET_W), .WAY_W(WAY_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .utlb_inv  (utlb_inv),
   .pd0_q     (pd0_q),
   .pd1_q     (pd1_q),
   .idx_q     (idx_q),
   .pid_q     (pid_q)
);

// File: tb/sim_tlb_cmd_engine.sv
module sim_tlb_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit;
   logic [18:0] lk_ppn;
   logic [6:0]  lk_attr;
   logic        utlb_inv;

   always #5 clk = ~clk;

   tlb_cmd_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_vaddr(lk_vaddr),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr), .utlb_inv(utlb_inv)
   );

   typedef struct { logic [31:0] val; string tag; } exp_t;
   exp_t        exp_q[$];
   logic [31:0] obs_val;
   event        obs_ev;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;
   logic [7:0]  lfsr_m = 8'hA5;

   // Monitor: pops the expected item for every observation
   initial begin
      forever begin
         @(obs_ev);
         begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (obs_val !== e.val) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", e.tag, obs_val, e.val);
            end
         end
      end
   end

   task automatic observe(input string tag, input logic [31:0] act, input logic [31:0] exp);
      exp_t e;
      e.val = exp; e.tag = tag;
      exp_q.push_back(e);
      obs_val = act;
      ->obs_ev;
      #1;
   endtask

   function automatic logic [31:0] tagd(input logic [18:0] vpn, input bit v, input bit g,
                                        input logic [7:0] asid);
      return {vpn, 3'b000, v, g, asid};
   endfunction
   function automatic logic [31:0] datd(input logic [18:0] ppn, input logic [6:0] attr);
      return {ppn, 6'b0, attr};
   endfunction
   function automatic logic [31:0] slot(input logic [18:0] vpn, input bit way);
      return {24'b0, vpn[6:0], way};
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
      @(negedge clk);
      reg_sel = sel;
      #1;
      observe(tag, reg_rdata, exp);
   endtask

   task automatic lk_chk(input string tag, input logic [31:0] va, input bit hit,
                         input logic [18:0] ppn, input logic [6:0] attr);
      @(negedge clk);
      lk_vaddr = va;
      #1;
      observe(tag, {12'b0, lk_hit, lk_ppn}, {12'b0, hit, ppn});
      observe(tag, {25'b0, lk_attr}, {25'b0, attr});
   endtask

   // command; checks the flush strobe the cycle after and the cycle after that
   task automatic cmd(input string tag, input logic [3:0] code, input bit strobe);
      wr(3'd3, {28'b0, code});
      observe(tag, {31'b0, utlb_inv}, {31'b0, strobe});
      @(negedge clk);
      observe(tag, {31'b0, utlb_inv}, 32'd0);
   endtask

   task automatic put(input logic [18:0] vpn, input bit way, input bit v, input bit g,
                      input logic [7:0] asid, input logic [18:0] ppn, input logic [6:0] attr,
                      input logic [3:0] code);
      wr(3'd0, tagd(vpn, v, g, asid));
      wr(3'd1, datd(ppn, attr));
      wr(3'd2, slot(vpn, way));
      cmd(code == 4'd1 ? "R3 write strobe" : "R4 quiet write strobe", code, code == 4'd1);
   endtask

   localparam logic [18:0] VA = 19'h00023;
   localparam logic [18:0] VB = 19'h01023;
   localparam logic [18:0] VC = 19'h00150;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      observe("R1 strobe", {31'b0, utlb_inv}, 32'd0);
      rd_chk("R1 tag desc", 3'd0, 32'd0);
      rd_chk("R1 data desc", 3'd1, 32'd0);
      rd_chk("R1 index", 3'd2, 32'd0);
      rd_chk("R1 proc", 3'd4, 32'd0);

      // R11 translation off
      lk_chk("R11 identity", 32'h1234_5678, 1'b1, 19'h091A2, 7'h3F);

      // R2 register window readback
      wr(3'd0, 32'hDEAD_BEEF); rd_chk("R2 tag desc", 3'd0, 32'hDEAD_BEEF);
      wr(3'd1, 32'h0BAD_F00D); rd_chk("R2 data desc", 3'd1, 32'h0BAD_F00D);
      wr(3'd2, 32'h0000_00C3); rd_chk("R2 index", 3'd2, 32'h0000_00C3);
      rd_chk("R2 command reads zero", 3'd3, 32'd0);

      // R1 all slots invalid after reset
      wr(3'd4, 32'h8000_0005);
      rd_chk("R2 proc", 3'd4, 32'h8000_0005);
      lk_chk("R1 no valid slot", {VA, 13'h0}, 1'b0, 19'd0, 7'd0);

      // R3 write and lookup
      put(VA, 1'b1, 1'b1, 1'b0, 8'd5, 19'h4_5678, 7'h25, 4'd1);
      lk_chk("R10 asid hit", {VA, 13'h1ABC}, 1'b1, 19'h4_5678, 7'h25);
      wr(3'd4, 32'h8000_0006);
      lk_chk("R10 asid mismatch", {VA, 13'h0}, 1'b0, 19'd0, 7'd0);

      // R4 quiet write of a global entry, same set other way
      put(VB, 1'b0, 1'b1, 1'b1, 8'd9, 19'h0_0ABC, 7'h52, 4'd5);
      lk_chk("R10 global hit", {VB, 13'h0}, 1'b1, 19'h0_0ABC, 7'h52);
      lk_chk("R10 vpn mismatch", {VC, 13'h0}, 1'b0, 19'd0, 7'd0);

      // R6 read back a slot
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd2, slot(VA, 1'b1));
      cmd("R6 read no strobe", 4'd2, 1'b0);
      rd_chk("R6 tag desc", 3'd0, tagd(VA, 1'b1, 1'b0, 8'd5));
      rd_chk("R6 data desc", 3'd1, datd(19'h4_5678, 7'h25));

      // R7 search hit, R8 search miss
      wr(3'd0, tagd(VA, 1'b0, 1'b0, 8'd5));
      cmd("R7 search", 4'd4, 1'b0);
      rd_chk("R7 search hit way 1", 3'd2, slot(VA, 1'b1));
      wr(3'd0, tagd(VA, 1'b0, 1'b0, 8'd7));
      cmd("R8 search", 4'd4, 1'b0);
      rd_chk("R8 search miss code", 3'd2, 32'h8000_0000);
      wr(3'd0, tagd(VB, 1'b0, 1'b0, 8'd77));
      cmd("R7 search global", 4'd4, 1'b0);
      rd_chk("R7 global hit way 0", 3'd2, slot(VB, 1'b0));

      // R9 pick index, three times
      for (int i = 0; i < 3; i++) begin
         wr(3'd0, tagd(VC + 19'(i), 1'b0, 1'b0, 8'd0));
         cmd("R9 pick", 4'd3, 1'b0);
         rd_chk("R9 pick index", 3'd2, slot(VC + 19'(i), lfsr_m[0]));
         lfsr_m = {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
      end

      // R5 flush only
      wr(3'd0, 32'h1111_0000); wr(3'd2, 32'h0000_0010);
      cmd("R5 flush strobe", 4'd6, 1'b1);
      rd_chk("R5 tag desc unchanged", 3'd0, 32'h1111_0000);
      rd_chk("R5 index unchanged", 3'd2, 32'h0000_0010);

      // R12 unknown codes
      cmd("R12 code 0", 4'd0, 1'b0);
      cmd("R12 code 9", 4'd9, 1'b0);
      cmd("R12 code 7", 4'd7, 1'b0);
      rd_chk("R12 tag desc", 3'd0, 32'h1111_0000);
      rd_chk("R12 index", 3'd2, 32'h0000_0010);
      rd_chk("R12 proc", 3'd4, 32'h8000_0006);
      lk_chk("R12 slot kept", {VB, 13'h0}, 1'b1, 19'h0_0ABC, 7'h52);

      // R7 duplicate tags: lower way wins
      put(VC, 1'b0, 1'b1, 1'b0, 8'd6, 19'h111, 7'h01, 4'd1);
      put(VC, 1'b1, 1'b1, 1'b0, 8'd6, 19'h222, 7'h02, 4'd1);
      wr(3'd0, tagd(VC, 1'b0, 1'b0, 8'd6));
      cmd("R7 dup search", 4'd4, 1'b0);
      rd_chk("R7 dup lower way", 3'd2, slot(VC, 1'b0));
      lk_chk("R10 dup lookup", {VC, 13'h0}, 1'b1, 19'h111, 7'h01);

      // R3 storing an invalid tag removes the slot
      put(VA, 1'b1, 1'b0, 1'b0, 8'd6, 19'h4_5678, 7'h25, 4'd1);
      wr(3'd4, 32'h8000_0006);
      lk_chk("R3 invalidated", {VA, 13'h0}, 1'b0, 19'd0, 7'd0);

      // R11 translation off again
      wr(3'd4, 32'h0000_0006);
      lk_chk("R11 identity again", {VA, 13'h0}, 1'b1, VA, 7'h3F);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule